// File: doc/BRIEF.md
# Cartridge Bank Select Controller

This block sits on the CPU write path of a cartridge slot. It snoops write cycles aimed at the read-only program window, 0x0000 to 0x7FFF. It turns the address and data of each such write into bank-select state: the program bank, the data-RAM bank, a RAM-enable flag and, in one variant, a clock-register select code. Address decoders and the storage arrays consume these outputs. The block itself holds no memory contents.

A synthesis-time parameter picks one of three register layouts:

- A 5+2-bit layout. It has a mode bit that steers a shared 2-bit field either to the upper program-bank bits or to the RAM bank.
- A 7-bit layout with a clock-register select and a latch strobe.
- A 9-bit layout, whose low byte and top bit are loaded from separate address ranges.

After each accepted write, both bank numbers are cut down to the bank counts given as parameters, which are powers of two.

Top module: `cart_bank_ctrl`

## Requirements
- R1: In every layout, a write to 0x0000–0x1FFF sets `ram_en_o` when data bits 3:0 equal 0xA. Any other value clears it.
- R2: In the 5+2 layout, a write to 0x2000–0x3FFF replaces program-bank bits 4:0 with data bits 4:0, keeps bits 6:5 and clears bits 8:7. A zero in data bits 4:0 is loaded as 1.
- R3: In the 5+2 layout, a write to 0x4000–0x5FFF takes data bits 1:0. With the mode bit at 0 they become program-bank bits 6:5. With the mode bit at 1 they become the RAM bank, and the program bank is left unchanged.
- R4: In the 5+2 layout, a write to 0x6000–0x7FFF loads the mode bit from data bit 0. This write changes no bank output.
- R5: In the 7-bit layout, a write to 0x2000–0x3FFF loads the program bank from data bits 6:0. A zero is loaded as 1.
- R6: In the 7-bit layout, a write to 0x4000–0x5FFF loads `clk_sel_o` with data bits 3:0 and the RAM bank with data bits 1:0. `clk_map_o` equals bit 3 of `clk_sel_o`.
- R7: In the 7-bit layout, a write to 0x6000–0x7FFF raises `latch_pulse_o` for exactly the next cycle. It leaves all bank outputs unchanged.
- R8: In the 9-bit layout, a write to 0x2000–0x2FFF loads program-bank bits 7:0 from the data, and a zero byte is loaded as 1. A write to 0x3000–0x3FFF loads bit 8 from data bit 0.
- R9: In the 9-bit layout, a write to 0x4000–0x5FFF loads the RAM bank from data bits 3:0. A write to 0x6000–0x7FFF has no effect.
- R10: After every accepted write, the program bank is ANDed with (ROM_BANKS−1) and the RAM bank with (RAM_BANKS−1). The zero-to-one substitution happens before this mask.
- R11: While `rst_ni` is low, the outputs read as follows: program bank 1, RAM bank 0, RAM disabled, clock select 0, mode bit 0 and no latch pulse.
- R12: A cycle with `wr_i` low, or a write to 0x8000–0xFFFF, leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | CPU write strobe, sampled on the rising edge |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| rom_bank_o | output | 9 | Program bank for the 0x4000–0x7FFF window |
| ram_bank_o | output | 4 | External RAM bank |
| ram_en_o | output | 1 | External RAM access enabled |
| clk_sel_o | output | 4 | Clock-register select code (7-bit layout only) |
| clk_map_o | output | 1 | RAM window maps to clock registers |
| latch_pulse_o | output | 1 | One-cycle clock latch strobe |

## Verification
Each layout gets its own write sequence, so that each mechanism can be seen in the outputs:

- Zero data in the low-bank range tells the zero-to-one substitution apart from a plain load.
- Nonzero upper data bits show which bits are masked off.
- A 5+2 instance is driven with the mode bit at both values, so a misrouted 2-bit field shows up as a wrong program or RAM bank.
- An instance with small bank counts is given bank values above those counts, which separates masking done after substitution from masking done before it.
- Strobe-low cycles and writes above 0x7FFF confirm that the state holds.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {FLV_5P2 = 2'd0, FLV_7 = 2'd1, FLV_9 = 2'd2} flavour_e;

  localparam int ROM_W = 9;
  localparam int RAM_W = 4;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    RG_ENABLE  = 2'd0,
    RG_BANK_LO = 2'd1,
    RG_BANK_HI = 2'd2,
    RG_CTRL    = 2'd3
  } region_e;

  typedef struct packed {
    logic [ROM_W-1:0] rom;
    logic [RAM_W-1:0] ram;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             mode;
  } bank_state_t;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
(
  input  logic       wr_i,
  input  logic [3:0] addr_hi_i,
  output logic       hit_o,
  output region_e    region_o,
  output logic       half_o
);
  assign hit_o    = wr_i & ~addr_hi_i[3];
  assign region_o = region_e'(addr_hi_i[2:1]);
  assign half_o   = addr_hi_i[0];
endmodule

// File: rtl/cbc_next.sv
module cbc_next
  import cbc_pkg::*;
#(
  parameter flavour_e FLAVOUR = FLV_5P2
) (
  input  logic        hit_i,
  input  region_e     region_i,
  input  logic        half_i,
  input  logic [7:0]  data_i,
  input  bank_state_t cur_i,
  output bank_state_t nxt_o,
  output logic        latch_o
);
  logic en_val;
  logic unused_in;

  assign en_val    = (data_i[3:0] == 4'hA);
  assign unused_in = ^{cur_i, data_i, half_i};

  if (FLAVOUR == FLV_5P2) begin : g_5p2
    logic [4:0] lo5;
    assign lo5 = (data_i[4:0] == 5'd0) ? 5'd1 : data_i[4:0];
    always_comb begin
      nxt_o   = cur_i;
      latch_o = 1'b0;
      if (hit_i) begin
        case (region_i)
          RG_ENABLE:  nxt_o.en = en_val;
          RG_BANK_LO: nxt_o.rom = {2'b00, cur_i.rom[6:5], lo5};
          RG_BANK_HI: begin
            if (cur_i.mode) nxt_o.ram = {2'b00, data_i[1:0]};
            else            nxt_o.rom = {2'b00, data_i[1:0], cur_i.rom[4:0]};
          end
          RG_CTRL:    nxt_o.mode = data_i[0];
          default: ;
        endcase
      end
    end
  end else if (FLAVOUR == FLV_7) begin : g_7
    logic [6:0] lo7;
    assign lo7 = (data_i[6:0] == 7'd0) ? 7'd1 : data_i[6:0];
    always_comb begin
      nxt_o   = cur_i;
      latch_o = 1'b0;
      if (hit_i) begin
        case (region_i)
          RG_ENABLE:  nxt_o.en = en_val;
          RG_BANK_LO: nxt_o.rom = {2'b00, lo7};
          RG_BANK_HI: begin
            nxt_o.sel = data_i[3:0];
            nxt_o.ram = {2'b00, data_i[1:0]};
          end
          RG_CTRL:    latch_o = 1'b1;
          default: ;
        endcase
      end
    end
  end else begin : g_9
    logic [7:0] lo8;
    assign lo8 = (data_i == 8'd0) ? 8'd1 : data_i;
    always_comb begin
      nxt_o   = cur_i;
      latch_o = 1'b0;
      if (hit_i) begin
        case (region_i)
          RG_ENABLE:  nxt_o.en = en_val;
          RG_BANK_LO: begin
            if (!half_i) nxt_o.rom = {cur_i.rom[8], lo8};
            else         nxt_o.rom = {data_i[0], cur_i.rom[7:0]};
          end
          RG_BANK_HI: nxt_o.ram = data_i[3:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cbc_state.sv
module cbc_state
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 128,
  parameter int RAM_BANKS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hit_i,
  input  bank_state_t nxt_i,
  input  logic        latch_i,
  output bank_state_t st_o,
  output logic        latch_o
);
  localparam logic [ROM_W-1:0] ROM_MASK = ROM_W'(ROM_BANKS - 1);
  localparam logic [RAM_W-1:0] RAM_MASK = RAM_W'(RAM_BANKS - 1);

  bank_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '0;
      st_q.rom <= ROM_W'(1);
      latch_o  <= 1'b0;
    end else begin
      latch_o <= latch_i;
      if (hit_i) begin
        st_q     <= nxt_i;
        st_q.rom <= nxt_i.rom & ROM_MASK;
        st_q.ram <= nxt_i.ram & RAM_MASK;
      end
    end
  end

  assign st_o = st_q;

  assert_rom_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.rom <= ROM_MASK);
  assert_ram_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.ram <= RAM_MASK);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(st_q));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter flavour_e FLAVOUR   = FLV_5P2,
  parameter int       ROM_BANKS = 128,
  parameter int       RAM_BANKS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  output logic [8:0]  rom_bank_o,
  output logic [3:0]  ram_bank_o,
  output logic        ram_en_o,
  output logic [3:0]  clk_sel_o,
  output logic        clk_map_o,
  output logic        latch_pulse_o
);
  localparam logic [8:0] ROM_MASK = 9'(ROM_BANKS - 1);

  logic        hit;
  region_e     region;
  logic        half;
  bank_state_t cur, nxt;
  logic        latch_nxt;
  logic        unused_addr;

  assign unused_addr = ^addr_i[11:0];

  cbc_decode u_dec (
    .wr_i      (wr_i),
    .addr_hi_i (addr_i[15:12]),
    .hit_o     (hit),
    .region_o  (region),
    .half_o    (half)
  );

  cbc_next #(.FLAVOUR(FLAVOUR)) u_nxt (
    .hit_i    (hit),
    .region_i (region),
    .half_i   (half),
    .data_i   (data_i),
    .cur_i    (cur),
    .nxt_o    (nxt),
    .latch_o  (latch_nxt)
  );

  cbc_state #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_st (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .nxt_i   (nxt),
    .latch_i (latch_nxt),
    .st_o    (cur),
    .latch_o (latch_pulse_o)
  );

  assign rom_bank_o = cur.rom;
  assign ram_bank_o = cur.ram;
  assign ram_en_o   = cur.en;
  assign clk_sel_o  = cur.sel;
  assign clk_map_o  = cur.sel[3];

  assert_ram_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'd0) |=> (ram_en_o == ($past(data_i[3:0]) == 4'hA)));
  assert_latch_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_pulse_o |-> $past(wr_i && addr_i[15:13] == 3'd3));

  if (FLAVOUR == FLV_7) begin : g_chk7
    assert_zero_sub_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i[15:13] == 3'd1 && data_i[6:0] == 7'd0) |=> rom_bank_o == (9'd1 & ROM_MASK));
    assert_sel_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i[15:13] == 3'd2) |=> clk_sel_o == $past(data_i[3:0]));
    assert_latch_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i[15:13] == 3'd3) |=> ($stable(rom_bank_o) && $stable(ram_bank_o)));
  end else begin : g_chk_nolatch
    assert_no_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !latch_pulse_o);
  end
endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
  import cbc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wr = '0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [8:0]  rom_o [4];
  logic [3:0]  ram_o [4];
  logic        en_o  [4];
  logic [3:0]  sel_o [4];
  logic        map_o [4];
  logic        lat_o [4];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cart_bank_ctrl #(.FLAVOUR(FLV_5P2), .ROM_BANKS(128), .RAM_BANKS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr[0]), .addr_i(addr), .data_i(data),
    .rom_bank_o(rom_o[0]), .ram_bank_o(ram_o[0]), .ram_en_o(en_o[0]),
    .clk_sel_o(sel_o[0]), .clk_map_o(map_o[0]), .latch_pulse_o(lat_o[0]));
  cart_bank_ctrl #(.FLAVOUR(FLV_7), .ROM_BANKS(128), .RAM_BANKS(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr[1]), .addr_i(addr), .data_i(data),
    .rom_bank_o(rom_o[1]), .ram_bank_o(ram_o[1]), .ram_en_o(en_o[1]),
    .clk_sel_o(sel_o[1]), .clk_map_o(map_o[1]), .latch_pulse_o(lat_o[1]));
  cart_bank_ctrl #(.FLAVOUR(FLV_9), .ROM_BANKS(512), .RAM_BANKS(16)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr[2]), .addr_i(addr), .data_i(data),
    .rom_bank_o(rom_o[2]), .ram_bank_o(ram_o[2]), .ram_en_o(en_o[2]),
    .clk_sel_o(sel_o[2]), .clk_map_o(map_o[2]), .latch_pulse_o(lat_o[2]));
  cart_bank_ctrl #(.FLAVOUR(FLV_5P2), .ROM_BANKS(16), .RAM_BANKS(2)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr[3]), .addr_i(addr), .data_i(data),
    .rom_bank_o(rom_o[3]), .ram_bank_o(ram_o[3]), .ram_en_o(en_o[3]),
    .clk_sel_o(sel_o[3]), .clk_map_o(map_o[3]), .latch_pulse_o(lat_o[3]));

  // {inst[1:0], addr[15:0], data[7:0], exp_rom[8:0], exp_ram[3:0], exp_en, exp_sel[3:0]}
  localparam int NV = 36;
  localparam logic [43:0] VEC [NV] = '{
    // u0, 5+2 layout: R1 R2 R3 R4 R12
    {2'd0, 16'h0000, 8'h0A, 9'h001, 4'h0, 1'b1, 4'h0},
    {2'd0, 16'h1FFF, 8'h1B, 9'h001, 4'h0, 1'b0, 4'h0},
    {2'd0, 16'h1234, 8'hFA, 9'h001, 4'h0, 1'b1, 4'h0},
    {2'd0, 16'h2000, 8'h13, 9'h013, 4'h0, 1'b1, 4'h0},
    {2'd0, 16'h4000, 8'h02, 9'h053, 4'h0, 1'b1, 4'h0},
    {2'd0, 16'h3FFF, 8'h00, 9'h041, 4'h0, 1'b1, 4'h0},
    {2'd0, 16'h3000, 8'hE7, 9'h047, 4'h0, 1'b1, 4'h0},
    {2'd0, 16'h6000, 8'h01, 9'h047, 4'h0, 1'b1, 4'h0},
    {2'd0, 16'h5FFF, 8'h03, 9'h047, 4'h3, 1'b1, 4'h0},
    {2'd0, 16'h6000, 8'hFE, 9'h047, 4'h3, 1'b1, 4'h0},
    {2'd0, 16'h4000, 8'h01, 9'h027, 4'h3, 1'b1, 4'h0},
    {2'd0, 16'h8000, 8'h00, 9'h027, 4'h3, 1'b1, 4'h0},
    {2'd0, 16'h2000, 8'h20, 9'h021, 4'h3, 1'b1, 4'h0},
    // u1, 7-bit layout: R5 R6 R7 R1 R12
    {2'd1, 16'h2000, 8'h00, 9'h001, 4'h0, 1'b0, 4'h0},
    {2'd1, 16'h2ABC, 8'hFF, 9'h07F, 4'h0, 1'b0, 4'h0},
    {2'd1, 16'h3000, 8'h80, 9'h001, 4'h0, 1'b0, 4'h0},
    {2'd1, 16'h4000, 8'h0A, 9'h001, 4'h2, 1'b0, 4'hA},
    {2'd1, 16'h4000, 8'h05, 9'h001, 4'h1, 1'b0, 4'h5},
    {2'd1, 16'h6000, 8'h01, 9'h001, 4'h1, 1'b0, 4'h5},
    {2'd1, 16'h0100, 8'h3A, 9'h001, 4'h1, 1'b1, 4'h5},
    {2'd1, 16'hA000, 8'h00, 9'h001, 4'h1, 1'b1, 4'h5},
    // u2, 9-bit layout: R8 R9 R1
    {2'd2, 16'h2000, 8'h00, 9'h001, 4'h0, 1'b0, 4'h0},
    {2'd2, 16'h2FFF, 8'hC5, 9'h0C5, 4'h0, 1'b0, 4'h0},
    {2'd2, 16'h3000, 8'h01, 9'h1C5, 4'h0, 1'b0, 4'h0},
    {2'd2, 16'h2000, 8'h00, 9'h101, 4'h0, 1'b0, 4'h0},
    {2'd2, 16'h3FFF, 8'hFE, 9'h001, 4'h0, 1'b0, 4'h0},
    {2'd2, 16'h4000, 8'h0F, 9'h001, 4'hF, 1'b0, 4'h0},
    {2'd2, 16'h5000, 8'hF3, 9'h001, 4'h3, 1'b0, 4'h0},
    {2'd2, 16'h6000, 8'h55, 9'h001, 4'h3, 1'b0, 4'h0},
    {2'd2, 16'h1000, 8'h0A, 9'h001, 4'h3, 1'b1, 4'h0},
    // u3, 5+2 layout with 16 ROM / 2 RAM banks: R10
    {2'd3, 16'h2000, 8'h1F, 9'h00F, 4'h0, 1'b0, 4'h0},
    {2'd3, 16'h6000, 8'h01, 9'h00F, 4'h0, 1'b0, 4'h0},
    {2'd3, 16'h4000, 8'h03, 9'h00F, 4'h1, 1'b0, 4'h0},
    {2'd3, 16'h6000, 8'h00, 9'h00F, 4'h1, 1'b0, 4'h0},
    {2'd3, 16'h4000, 8'h03, 9'h00F, 4'h1, 1'b0, 4'h0},
    {2'd3, 16'h2000, 8'h10, 9'h000, 4'h1, 1'b0, 4'h0}
  };

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int i, input logic [8:0] r,
                         input logic [3:0] m, input logic e, input logic [3:0] s);
    chk($sformatf("%s u%0d rom", tag, i), rom_o[i], r);
    chk($sformatf("%s u%0d ram", tag, i), ram_o[i], m);
    chk($sformatf("%s u%0d en", tag, i), en_o[i], e);
    chk($sformatf("%s u%0d sel", tag, i), sel_o[i], s);
    chk($sformatf("%s u%0d map (R6)", tag, i), map_o[i], s[3]);
  endtask

  task automatic wr_cycle(input int i, input logic [15:0] a, input logic [7:0] d);
    addr = a;
    data = d;
    wr = 4'(1 << i);
    @(negedge clk);
    wr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int i = 0; i < 4; i++) begin
      chk_all("R11 reset", i, 9'h001, 4'h0, 1'b0, 4'h0);
      chk($sformatf("R11 reset u%0d latch", i), lat_o[i], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int i;
      i = int'(VEC[v][43:42]);
      wr_cycle(i, VEC[v][41:26], VEC[v][25:18]);
      chk_all($sformatf("vec %0d", v), i, VEC[v][17:9], VEC[v][8:5], VEC[v][4], VEC[v][3:0]);
    end

    // R12: strobe low with an in-range address
    addr = 16'h2000;
    data = 8'h00;
    wr = '0;
    repeat (2) @(negedge clk);
    chk("R12 strobe low u0 rom", rom_o[0], 9'h021);
    chk("R12 strobe low u2 ram", ram_o[2], 4'h3);

    // R7: latch pulse lasts one cycle, banks unchanged
    wr_cycle(1, 16'h7FFF, 8'h00);
    chk("R7 latch high", lat_o[1], 1);
    chk("R7 rom kept", rom_o[1], 9'h001);
    chk("R7 ram kept", ram_o[1], 4'h1);
    @(negedge clk);
    chk("R7 latch one cycle", lat_o[1], 0);
    // R7: no pulse from other layouts
    wr_cycle(0, 16'h6000, 8'h00);
    chk("R7 no latch in 5+2", lat_o[0], 0);
    wr_cycle(2, 16'h7000, 8'h01);
    chk("R7 no latch in 9-bit", lat_o[2], 0);

    // R5: 0x80 written again after a nonzero bank
    wr_cycle(1, 16'h2000, 8'h42);
    chk("R5 load", rom_o[1], 9'h042);
    wr_cycle(1, 16'h2000, 8'h80);
    chk("R5 zero to one", rom_o[1], 9'h001);

    // R11: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk_all("R11 rerun", i, 9'h001, 4'h0, 1'b0, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: mode bit cleared by reset, so the field goes to the program bank
    wr_cycle(0, 16'h4000, 8'h03);
    chk("R4 mode reset", rom_o[0], 9'h061);
    chk("R4 mode reset ram", ram_o[0], 4'h0);

    finish_run();
  end
endmodule